// File: doc/BRIEF.md
# Diminished-one adder modulo 2^n+1

This block adds two residues modulo 2^n+1. Each operand is given on an n-bit data word together with a zero flag. When the flag is low, the word holds the true value minus one. When the flag is high, the true value is zero and the word is ignored. The result uses the same form: an n-bit word and a zero flag. Inside, the adder has three stages. A bitwise pre-processing stage forms generate, propagate and complemented half-sum bits. A parallel-prefix carry network uses inverting cells, so its levels alternate between true and complemented polarity. The network ends with one level that folds in the inverted end-around carry. A sum stage then merges the carries with the complemented half-sums.

The datapath is combinational. The parameter `OUT_REG` selects either one output register stage (value 1) or a direct combinational output (value 0). The register is cleared by an asynchronous active-low reset, and a two-flop synchroniser releases that reset in step with the clock. Operand width is set by `N`, with N of at least 2.

Top module: `dm1_mod_adder`

## Requirements
- R1: With both zero flags low, the result is the diminished-one form of ((A+1)+(B+1)) mod (2^N+1), where A and B are the operand words read as unsigned numbers.
- R2: With both zero flags low and A+B equal to 2^N-1, the true sum is the modulus. `sum_zero_o` is then 1 and `sum_o` is all zeros.
- R3: With both zero flags low and A+B of at least 2^N, the carry leaving the top of the prefix network is 1, and `sum_o` equals A+B-2^N.
- R4: With `opa_zero_i`=1 and `opb_zero_i`=0, the result equals operand B (`sum_o`=B, `sum_zero_o`=0), whatever value is on `opa_i`.
- R5: With `opb_zero_i`=1 and `opa_zero_i`=0, the result equals operand A (`sum_o`=A, `sum_zero_o`=0), whatever value is on `opb_i`.
- R6: With both zero flags high, `sum_zero_o` is 1 and `sum_o` is all zeros, whatever values are on the data words.
- R7: Whenever `sum_zero_o` is 1, `sum_o` is all zeros.
- R8: With `OUT_REG`=1, the result appears one clock edge after the operands. With `OUT_REG`=0, it follows the operands within the same cycle.
- R9: With `OUT_REG`=1 and `rst_n` low, `sum_o` is 0 and `sum_zero_o` is 1.
- R10: R1 to R7 hold at every width N of at least 2. They are checked exhaustively at N=4 and on directed and random operands at N=16 and N=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opa_i | input | N | Operand A, diminished-one word |
| opa_zero_i | input | 1 | Operand A is zero |
| opb_i | input | N | Operand B, diminished-one word |
| opb_zero_i | input | 1 | Operand B is zero |
| sum_o | output | N | Sum, diminished-one word |
| sum_zero_o | output | 1 | Sum is zero |

## Verification
Two things can happen to the same result word: a zero flag overriding the data path, and the end-around carry or the wrap to zero. The bench provokes them together. It raises one operand's zero flag while the data words would, on their own, produce a carry out or an exact wrap, for example all-ones on the flagged word or a word that is the complement of the other. The result is judged against an integer reference that converts both operands to true values, reduces the sum modulo 2^N+1 and converts back. A correct result therefore shows the bypassed operand unchanged, with the wrap and carry effects of the ignored word nowhere in the output.

// File: rtl/dm1_pkg.sv
package dm1_pkg;
  // Number of prefix levels needed to span n bits
  function automatic int prefix_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/dm1_preproc.sv
module dm1_preproc #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] gen_o,
  output logic [N-1:0] prop_o,
  output logic [N-1:0] hsum_n_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign gen_o[i]    = a_i[i] & b_i[i];
    assign prop_o[i]   = a_i[i] | b_i[i];
    assign hsum_n_o[i] = ~(a_i[i] ^ b_i[i]);
  end
endmodule

// File: rtl/dm1_prefix_net.sv
module dm1_prefix_net
  import dm1_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  output logic [N-1:0] carry_o,
  output logic         cout_o
);
  localparam int LVL = prefix_levels(N);
  localparam bit END_INV = (LVL % 2) == 1;

  // level k holds group signals; odd levels are stored complemented
  logic [LVL:0][N-1:0] gl;
  logic [LVL:0][N-1:0] pl;

  assign gl[0] = gen_i;
  assign pl[0] = prop_i;

  for (genvar k = 0; k < LVL; k++) begin : g_lvl
    localparam int SPAN = 1 << k;
    localparam bit IN_COMPL = (k % 2) == 1;
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i >= SPAN) begin : g_merge
        if (!IN_COMPL) begin : g_aoi
          // true inputs, complemented outputs
          assign gl[k+1][i] = ~(gl[k][i] | (pl[k][i] & gl[k][i-SPAN]));
          assign pl[k+1][i] = ~(pl[k][i] & pl[k][i-SPAN]);
        end else begin : g_oai
          // complemented inputs, true outputs
          assign gl[k+1][i] = ~(gl[k][i] & (pl[k][i] | gl[k][i-SPAN]));
          assign pl[k+1][i] = ~(pl[k][i] | pl[k][i-SPAN]);
        end
      end else begin : g_pass
        // inverter keeps the whole level in one polarity
        assign gl[k+1][i] = ~gl[k][i];
        assign pl[k+1][i] = ~pl[k][i];
      end
    end
  end

  // re-read the last level in true polarity
  logic [N-1:0] grp_g;
  logic [N-1:0] grp_p;
  if (END_INV) begin : g_fix_inv
    assign grp_g = ~gl[LVL];
    assign grp_p = ~pl[LVL];
  end else begin : g_fix_true
    assign grp_g = gl[LVL];
    assign grp_p = pl[LVL];
  end

  // end-around level: inverted carry-out re-enters at bit 0
  logic cin_w;
  assign cout_o  = grp_g[N-1];
  assign cin_w   = ~grp_g[N-1];
  assign carry_o[0] = cin_w;
  for (genvar i = 1; i < N; i++) begin : g_eac
    assign carry_o[i] = grp_g[i-1] | (grp_p[i-1] & cin_w);
  end
endmodule

// File: rtl/dm1_sum_stage.sv
module dm1_sum_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] hsum_n_i,
  input  logic [N-1:0] carry_i,
  output logic [N-1:0] sum_o,
  output logic         wrap_o
);
  // half-sum arrives complemented, so the merge is an XNOR
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum_o[i] = ~(hsum_n_i[i] ^ carry_i[i]);
  end
  // every half-sum set: operands add to 2^N-1, true sum equals the modulus
  assign wrap_o = ~|hsum_n_i;
endmodule

// File: rtl/dm1_mod_adder.sv
module dm1_mod_adder #(
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] opa_i,
  input  logic         opa_zero_i,
  input  logic [N-1:0] opb_i,
  input  logic         opb_zero_i,
  output logic [N-1:0] sum_o,
  output logic         sum_zero_o
);
  localparam int NW = N + 1;

  logic [N-1:0] gen_w, prop_w, hsn_w, carry_w, raw_w;
  logic         cout_w, wrap_w;

  dm1_preproc #(.N(N)) u_pre (
    .a_i(opa_i), .b_i(opb_i),
    .gen_o(gen_w), .prop_o(prop_w), .hsum_n_o(hsn_w)
  );

  dm1_prefix_net #(.N(N)) u_pfx (
    .gen_i(gen_w), .prop_i(prop_w),
    .carry_o(carry_w), .cout_o(cout_w)
  );

  dm1_sum_stage #(.N(N)) u_sum (
    .hsum_n_i(hsn_w), .carry_i(carry_w),
    .sum_o(raw_w), .wrap_o(wrap_w)
  );

  // zero-flag bypass and wrap handling
  logic [N-1:0] nxt_sum;
  logic         nxt_zero;
  always_comb begin
    nxt_sum  = raw_w;
    nxt_zero = 1'b0;
    unique case ({opa_zero_i, opb_zero_i})
      2'b11: begin nxt_sum = '0;    nxt_zero = 1'b1; end
      2'b10: begin nxt_sum = opb_i; nxt_zero = 1'b0; end
      2'b01: begin nxt_sum = opa_i; nxt_zero = 1'b0; end
      default: begin
        if (wrap_w) begin
          nxt_sum  = '0;
          nxt_zero = 1'b1;
        end
      end
    endcase
  end

  // R2
  wrap_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |-> (raw_w == '0));

  // R3
  cout_adder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cout_w == ((NW'(opa_i) + NW'(opb_i)) >> N));

  // R7
  zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_zero_o |-> (sum_o == '0));

  if (OUT_REG) begin : g_reg
    logic [1:0]   rst_sync_q;
    logic         rst_q_n;
    logic [N-1:0] sum_q;
    logic         zero_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_sync_q <= 2'b00;
      else        rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
    assign rst_q_n = rst_sync_q[1];

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        sum_q  <= '0;
        zero_q <= 1'b1;
      end else begin
        sum_q  <= nxt_sum;
        zero_q <= nxt_zero;
      end
    end
    assign sum_o      = sum_q;
    assign sum_zero_o = zero_q;

    // R6
    both_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q_n && opa_zero_i && opb_zero_i) |=> (sum_zero_o && sum_o == '0));
    // R4
    a_bypass_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q_n && opa_zero_i && !opb_zero_i) |=> (!sum_zero_o && sum_o == $past(opb_i)));
    // R5
    b_bypass_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q_n && opb_zero_i && !opa_zero_i) |=> (!sum_zero_o && sum_o == $past(opa_i)));
  end else begin : g_comb
    assign sum_o      = nxt_sum;
    assign sum_zero_o = nxt_zero;

    // R6
    both_zero_cmb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opa_zero_i && opb_zero_i) |-> (sum_zero_o && sum_o == '0));
    // R4
    a_bypass_cmb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opa_zero_i && !opb_zero_i) |-> (!sum_zero_o && sum_o == opb_i));
    // R5
    b_bypass_cmb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opb_zero_i && !opa_zero_i) |-> (!sum_zero_o && sum_o == opa_i));
  end
endmodule

// File: tb/dm1_mod_adder_test.sv
module dm1_mod_adder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // N=16, registered
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        az16 = 1'b0, bz16 = 1'b0, sz16;
  // N=32, combinational
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic        az32 = 1'b0, bz32 = 1'b0, sz32;
  // N=4, combinational
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic        az4 = 1'b0, bz4 = 1'b0, sz4;

  dm1_mod_adder #(.N(16), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .opa_i(a16), .opa_zero_i(az16),
    .opb_i(b16), .opb_zero_i(bz16), .sum_o(s16), .sum_zero_o(sz16));
  dm1_mod_adder #(.N(32), .OUT_REG(1'b0)) uut32 (
    .clk(clk), .rst_n(rst_n), .opa_i(a32), .opa_zero_i(az32),
    .opb_i(b32), .opb_zero_i(bz32), .sum_o(s32), .sum_zero_o(sz32));
  dm1_mod_adder #(.N(4), .OUT_REG(1'b0)) uut4 (
    .clk(clk), .rst_n(rst_n), .opa_i(a4), .opa_zero_i(az4),
    .opb_i(b4), .opb_zero_i(bz4), .sum_o(s4), .sum_zero_o(sz4));

  // reference: {zero flag, 32-bit data}
  function automatic logic [32:0] ref_fn(input int n, input longint a, input bit az,
                                         input longint b, input bit bz);
    longint m, ta, tb, s;
    m  = (longint'(1) << n) + 1;
    ta = az ? 0 : a + 1;
    tb = bz ? 0 : b + 1;
    s  = (ta + tb) % m;
    if (s == 0) return {1'b1, 32'd0};
    return {1'b0, 32'(s - 1)};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual zero=%0b data=%h expected zero=%0b data=%h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic run16(input logic [15:0] a, input bit az, input logic [15:0] b,
                       input bit bz, input string req);
    @(negedge clk);
    a16 = a; az16 = az; b16 = b; bz16 = bz;
    @(negedge clk);
    check(req, {sz16, 16'd0, s16}, ref_fn(16, longint'(a), az, longint'(b), bz));
  endtask

  task automatic run32(input logic [31:0] a, input bit az, input logic [31:0] b,
                       input bit bz, input string req);
    @(negedge clk);
    a32 = a; az32 = az; b32 = b; bz32 = bz;
    #1;
    check(req, {sz32, s32}, ref_fn(32, longint'(a), az, longint'(b), bz));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 reset state", {s16 == 16'd0 ? 1'b0 : 1'b1, 31'd0, sz16}, {1'b0, 31'd0, 1'b1});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_nonzero;
    run16(16'h0000, 0, 16'h0000, 0, "R1 one plus one");
    run16(16'h1234, 0, 16'h0F0F, 0, "R1 mixed");
    run16(16'h7FFF, 0, 16'h0001, 0, "R1 mid");
    run32(32'h0000_0003, 0, 32'h0000_0004, 0, "R1 n32 small");
    run32(32'h89AB_CDEF, 0, 32'h0123_4567, 0, "R1 n32 mixed");
  endtask

  task automatic t_wrap;
    run16(16'h1234, 0, 16'hEDCB, 0, "R2 wrap to modulus");
    run16(16'hFFFF, 0, 16'h0000, 0, "R2 wrap all-ones");
    run32(32'hA5A5_0F0F, 0, 32'h5A5A_F0F0, 0, "R2 n32 wrap");
  endtask

  task automatic t_carry;
    run16(16'hFFFF, 0, 16'hFFFF, 0, "R3 all-ones carry");
    run16(16'h8000, 0, 16'h8000, 0, "R3 top bits carry");
    run16(16'hFFFF, 0, 16'h0001, 0, "R3 carry by one");
    run32(32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, "R3 n32 all-ones");
  endtask

  task automatic t_zero_a;
    run16(16'hFFFF, 1, 16'h0001, 0, "R4 a zero, a data all-ones");
    run16(16'h8001, 1, 16'h7FFE, 0, "R4 a zero, would wrap");
    run32(32'hFFFF_FFFF, 1, 32'h1357_9BDF, 0, "R4 n32 a zero");
  endtask

  task automatic t_zero_b;
    run16(16'hABCD, 0, 16'hFFFF, 1, "R5 b zero, would carry");
    run16(16'h00FF, 0, 16'hFF00, 1, "R5 b zero, would wrap");
    run32(32'h0000_0000, 0, 32'hDEAD_BEEF, 1, "R5 n32 b zero");
  endtask

  task automatic t_both;
    run16(16'hFFFF, 1, 16'hFFFF, 1, "R6 both zero all-ones data");
    run16(16'h1234, 1, 16'hEDCB, 1, "R6 both zero wrap data");
    run32(32'h0F0F_0F0F, 1, 32'hF0F0_F0F0, 1, "R6 n32 both zero");
  endtask

  task automatic t_flag_data;
    // R7: flag high implies data zero
    run16(16'h5555, 0, 16'hAAAA, 0, "R2 wrap for R7");
    check("R7 flag implies zero data", {sz16 & (s16 != 16'd0), 32'd0}, 33'd0);
  endtask

  task automatic t_latency;
    // R8: registered output holds old result until the edge
    logic [32:0] prev;
    run16(16'h0010, 0, 16'h0020, 0, "R8 setup");
    prev = {sz16, 16'd0, s16};
    a16 = 16'h0100; b16 = 16'h0200;
    #1;
    check("R8 registered holds before edge", {sz16, 16'd0, s16}, prev);
    @(negedge clk);
    check("R8 registered after one edge", {sz16, 16'd0, s16},
          ref_fn(16, 64'h100, 0, 64'h200, 0));
    a32 = 32'h0000_0100; az32 = 0; b32 = 32'h0000_0200; bz32 = 0;
    #1;
    check("R8 combinational same cycle", {sz32, s32}, ref_fn(32, 64'h100, 0, 64'h200, 0));
  endtask

  task automatic t_exh4;
    // R10: every combination at N=4, index 16 means zero flag
    for (int i = 0; i <= 16; i++) begin
      for (int j = 0; j <= 16; j++) begin
        @(negedge clk);
        a4 = 4'(i); az4 = (i == 16);
        b4 = 4'(j); bz4 = (j == 16);
        #1;
        check("R10 exhaustive n4", {sz4, 28'd0, s4},
              ref_fn(4, longint'(i & 15), i == 16, longint'(j & 15), j == 16));
      end
    end
  endtask

  task automatic t_rand;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      run32(ra, (k % 23) == 0, rb, (k % 29) == 0, "R10 random n32");
      if (k % 3 == 0) run16(ra[15:0], (k % 31) == 0, ~ra[15:0] ^ 16'(k % 2), 0, "R10 random n16");
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED));
    t_reset;
    t_nonzero;
    t_wrap;
    t_carry;
    t_zero_a;
    t_zero_b;
    t_both;
    t_flag_data;
    t_latency;
    t_exh4;
    t_rand;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule